// File: doc/BRIEF.md
# Vector Predicate Element-Count Decoder

This block works out how many vector elements a predicate-generating operation should mark active. It takes a 5-bit pattern code, an element-size select and the current vector length in bits. From the vector length and the element size it derives the number of elements that fit in one vector. It then maps that number through the pattern code to an active-element count.

The pattern map has three kinds of rule. The first is a round-down to a power of two. The second is a set of fixed constants, each of which falls to zero when the vector holds fewer elements than the constant. The third is a group of multiple-of-three, multiple-of-four and whole-vector rules.

A request is presented with `valid_i`. The count appears on `count_o` together with `valid_o` on the following clock edge. The vector length is a multiple of 128 bits, up to 2048 bits. Requests may arrive on every cycle.

Top module: `vpc_count_dec`

## Requirements
- R1: The element count is `vl_i` divided by the element size. The element size is 8, 16, 32 or 64 bits for `esz_i` = 0, 1, 2 or 3. With a 2048-bit vector the count never exceeds 256.
- R2: Pattern code 0 (binary 00000) yields the largest power of two not above the element count. It yields 0 when the count is 0.
- R3: Pattern codes 1 to 8 yield the constant equal to the code when the element count is at least that constant. Otherwise they yield 0.
- R4: Pattern codes 9 to 13 yield 16, 32, 64, 128 and 256 respectively when the element count is at least that value. Otherwise they yield 0.
- R5: Pattern code 29 (binary 11101) yields the element count rounded down to a multiple of 4.
- R6: Pattern code 30 (binary 11110) yields the element count rounded down to a multiple of 3.
- R7: Pattern code 31 (binary 11111) yields the full element count.
- R8: Pattern codes 14 to 28 yield 0.
- R9: `valid_o` is high in the cycle after each clock edge at which `valid_i` was high, and low otherwise. Requests on consecutive cycles each produce a result.
- R10: When no request was taken at an edge, `count_o` keeps its previous value, whatever the other inputs do.
- R11: While `rst_ni` is low, `valid_o` and `count_o` are 0. This takes effect without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| pattern_i | input | 5 | Pattern code |
| esz_i | input | 2 | Element size select: 0=8, 1=16, 2=32, 3=64 bits |
| vl_i | input | 12 | Vector length in bits |
| valid_o | output | 1 | Result valid, one cycle after the request |
| count_o | output | 9 | Active-element count |

## Verification
Two events can fall in the same clock edge. The result of one request is written to the output register at the same edge that captures the next request. The table walk drives a new vector on every cycle with no idle gaps. Each count is judged one cycle after its request, so a result that was overwritten or delayed shows up as a mismatch against the following entry.

A second collision is an idle edge against the previous result. The bench drops the strobe while it changes pattern and length, then checks that the previous count is still held.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
  localparam int unsigned PAT_W   = 5;
  localparam int unsigned ESZ_W   = 2;
  localparam int unsigned ESZ_LOG = 3;  // smallest element = 8 bits

  typedef enum logic [ESZ_W-1:0] {
    ESZ_8  = 2'd0,
    ESZ_16 = 2'd1,
    ESZ_32 = 2'd2,
    ESZ_64 = 2'd3
  } esz_e;

  localparam logic [PAT_W-1:0] PAT_POW2    = 5'd0;
  localparam logic [PAT_W-1:0] PAT_FIX_LIN = 5'd8;   // last linear constant
  localparam logic [PAT_W-1:0] PAT_FIX_TOP = 5'd13;  // last power-of-two constant
  localparam logic [PAT_W-1:0] PAT_FIX_OFS = 5'd5;   // 9 -> 2^4
  localparam logic [PAT_W-1:0] PAT_MUL4    = 5'd29;
  localparam logic [PAT_W-1:0] PAT_MUL3    = 5'd30;
  localparam logic [PAT_W-1:0] PAT_ALL     = 5'd31;
endpackage

// File: rtl/vpc_elem_count.sv
module vpc_elem_count #(
  parameter int unsigned VL_W  = 12,
  parameter int unsigned CNT_W = 9
) (
  input  logic [VL_W-1:0]            vl_i,
  input  logic [vpc_pkg::ESZ_W-1:0]  esz_i,
  output logic [CNT_W-1:0]           cnt_o
);
  import vpc_pkg::*;

  // vector length is a multiple of 8 bits at least; low bits never matter
  logic [VL_W-ESZ_LOG-1:0] vl_bytes;
  logic                    unused_lo;

  assign vl_bytes  = vl_i[VL_W-1:ESZ_LOG];
  assign unused_lo = ^vl_i[ESZ_LOG-1:0];

  always_comb begin
    cnt_o = CNT_W'(vl_bytes >> esz_i);
  end
endmodule

// File: rtl/vpc_floor_pow2.sv
module vpc_floor_pow2 #(
  parameter int unsigned CNT_W = 9
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] pow2_o
);
  // prefix-OR from the top; keep only the highest set bit
  logic [CNT_W:0] above;
  assign above[CNT_W] = 1'b0;

  for (genvar g = CNT_W - 1; g >= 0; g--) begin : g_bit
    assign above[g]  = above[g+1] | cnt_i[g];
    assign pow2_o[g] = cnt_i[g] & ~above[g+1];
  end
endmodule

// File: rtl/vpc_pattern_map.sv
module vpc_pattern_map #(
  parameter int unsigned CNT_W = 9
) (
  input  logic [CNT_W-1:0]          cnt_i,
  input  logic [vpc_pkg::PAT_W-1:0] pat_i,
  output logic [CNT_W-1:0]          num_o
);
  import vpc_pkg::*;

  logic [CNT_W-1:0] pow2;
  logic [CNT_W-1:0] fix_k;
  logic [CNT_W-1:0] fix_val;
  logic [CNT_W-1:0] mul3;
  logic [CNT_W-1:0] mul4;

  vpc_floor_pow2 #(.CNT_W(CNT_W)) u_pow2 (
    .cnt_i  (cnt_i),
    .pow2_o (pow2)
  );

  // one shared comparator for both constant groups
  always_comb begin
    if (pat_i <= PAT_FIX_LIN) fix_k = CNT_W'(pat_i);
    else                      fix_k = CNT_W'(1) << (pat_i - PAT_FIX_OFS);
    fix_val = (cnt_i >= fix_k) ? fix_k : '0;
  end

  assign mul4 = {cnt_i[CNT_W-1:2], 2'b00};
  assign mul3 = cnt_i - (cnt_i % CNT_W'(3));

  always_comb begin
    if (pat_i == PAT_POW2)         num_o = pow2;
    else if (pat_i <= PAT_FIX_TOP) num_o = fix_val;
    else if (pat_i == PAT_MUL4)    num_o = mul4;
    else if (pat_i == PAT_MUL3)    num_o = mul3;
    else if (pat_i == PAT_ALL)     num_o = cnt_i;
    else                           num_o = '0;
  end
endmodule

// File: rtl/vpc_count_dec.sv
module vpc_count_dec #(
  parameter  int unsigned VL_MAX = 2048,
  localparam int unsigned VL_W   = $clog2(VL_MAX) + 1,
  localparam int unsigned CNT_W  = $clog2(VL_MAX / 8) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [4:0]       pattern_i,
  input  logic [1:0]       esz_i,
  input  logic [VL_W-1:0]  vl_i,
  output logic             valid_o,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] elem_cnt;
  logic [CNT_W-1:0] num;

  vpc_elem_count #(.VL_W(VL_W), .CNT_W(CNT_W)) u_elem (
    .vl_i  (vl_i),
    .esz_i (esz_i),
    .cnt_o (elem_cnt)
  );

  vpc_pattern_map #(.CNT_W(CNT_W)) u_map (
    .cnt_i (elem_cnt),
    .pat_i (pattern_i),
    .num_o (num)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      count_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) count_o <= num;
    end
  end
endmodule

// File: rtl/vpc_count_dec_chk.sv
module vpc_count_dec_chk #(
  parameter int unsigned CNT_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [4:0]       pattern_i,
  input logic             valid_o,
  input logic [CNT_W-1:0] count_o
);
  logic       armed;
  logic       prev_v;
  logic [4:0] prev_pat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed    <= 1'b0;
      prev_v   <= 1'b0;
      prev_pat <= '0;
    end else begin
      armed    <= 1'b1;
      prev_v   <= valid_i;
      prev_pat <= pattern_i;
    end
  end

  logic res;
  assign res = armed && prev_v;

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> valid_o == prev_v);                                        // R9
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !prev_v) |-> $stable(count_o));                            // R10
  AST_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> count_o <= CNT_W'(256));                                 // R1
  AST_POW2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res && prev_pat == 5'd0) |-> $countones(count_o) <= 1);             // R2
  AST_FIX_LIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res && prev_pat >= 5'd1 && prev_pat <= 5'd8)
      |-> (count_o == '0 || count_o == CNT_W'(prev_pat)));               // R3
  AST_FIX_POW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res && prev_pat >= 5'd9 && prev_pat <= 5'd13)
      |-> (count_o == '0 || $countones(count_o) == 1 && count_o >= CNT_W'(16))); // R4
  AST_MUL4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res && prev_pat == 5'd29) |-> count_o[1:0] == 2'b00);               // R5
  AST_MUL3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res && prev_pat == 5'd30) |-> (count_o % CNT_W'(3)) == '0);         // R6
  AST_OTHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res && prev_pat >= 5'd14 && prev_pat <= 5'd28) |-> count_o == '0);  // R8
endmodule

bind vpc_count_dec vpc_count_dec_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .pattern_i (pattern_i),
  .valid_o   (valid_o),
  .count_o   (count_o)
);

// File: tb/sim_vpc_count_dec.sv
module sim_vpc_count_dec;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [4:0] pattern_i = '0;
  logic [1:0] esz_i = '0;
  logic [11:0] vl_i = '0;
  logic       valid_o;
  logic [8:0] count_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  vpc_count_dec u0 (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .pattern_i (pattern_i),
    .esz_i     (esz_i),
    .vl_i      (vl_i),
    .valid_o   (valid_o),
    .count_o   (count_o)
  );

  // {req id, pattern, esize sel, vector length, expected count}
  localparam int NV = 23;
  localparam logic [31:0] VEC [NV] = '{
    {4'd2,  5'd0,  2'd0, 12'd2048, 9'd256},  // R2 exact power
    {4'd2,  5'd0,  2'd0, 12'd384,  9'd32 },  // R2 48 -> 32
    {4'd2,  5'd0,  2'd3, 12'd128,  9'd2  },  // R2 R1 64-bit elems
    {4'd2,  5'd0,  2'd0, 12'd1920, 9'd128},  // R2 240 -> 128
    {4'd3,  5'd5,  2'd2, 12'd128,  9'd0  },  // R3 too few
    {4'd3,  5'd4,  2'd2, 12'd128,  9'd4  },  // R3 exactly enough
    {4'd3,  5'd8,  2'd0, 12'd128,  9'd8  },  // R3
    {4'd3,  5'd1,  2'd3, 12'd128,  9'd1  },  // R3
    {4'd4,  5'd9,  2'd0, 12'd128,  9'd16 },  // R4 exactly enough
    {4'd4,  5'd10, 2'd0, 12'd128,  9'd0  },  // R4 too few
    {4'd4,  5'd13, 2'd0, 12'd2048, 9'd256},  // R4 max
    {4'd4,  5'd13, 2'd0, 12'd1920, 9'd0  },  // R4
    {4'd4,  5'd11, 2'd1, 12'd1024, 9'd64 },  // R4
    {4'd4,  5'd12, 2'd1, 12'd2048, 9'd128},  // R4
    {4'd5,  5'd29, 2'd1, 12'd1920, 9'd120},  // R5 already multiple
    {4'd5,  5'd29, 2'd3, 12'd640,  9'd8  },  // R5 10 -> 8
    {4'd6,  5'd30, 2'd3, 12'd640,  9'd9  },  // R6 10 -> 9
    {4'd6,  5'd30, 2'd0, 12'd2048, 9'd255},  // R6 256 -> 255
    {4'd8,  5'd14, 2'd0, 12'd2048, 9'd0  },  // R8
    {4'd8,  5'd28, 2'd0, 12'd2048, 9'd0  },  // R8
    {4'd7,  5'd31, 2'd0, 12'd0,    9'd0  },  // R7 R2 zero elems
    {4'd1,  5'd31, 2'd2, 12'd2048, 9'd64 },  // R1 R7 32-bit elems
    {4'd7,  5'd31, 2'd1, 12'd1152, 9'd72 }   // R7
  };

  task automatic check(input string req, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic check_vec(input logic [31:0] v);
    string r;
    r = $sformatf("R%0d", v[31:28]);
    check("R9 valid", valid_o == 1'b1, int'(valid_o), 1);
    check(r, count_o == v[8:0], int'(count_o), int'(v[8:0]));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R11 reset valid", valid_o == 1'b0, int'(valid_o), 0);
    check("R11 reset count", count_o == '0, int'(count_o), 0);
    rst_ni = 1'b1;

    // back-to-back walk: result of i-1 is checked while i is presented
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      if (i > 0) check_vec(VEC[i-1]);
      valid_i   = 1'b1;
      pattern_i = VEC[i][27:23];
      esz_i     = VEC[i][22:21];
      vl_i      = VEC[i][20:9];
    end
    @(negedge clk_i);
    check_vec(VEC[NV-1]);

    // R10: idle cycles with changing inputs leave the count alone
    valid_i   = 1'b0;
    pattern_i = 5'd31;
    vl_i      = 12'd2048;
    esz_i     = 2'd0;
    @(negedge clk_i);
    check("R9 idle", valid_o == 1'b0, int'(valid_o), 0);
    pattern_i = 5'd0;
    @(negedge clk_i);
    check("R10 hold", count_o == 9'd72, int'(count_o), 72);
    check("R9 idle", valid_o == 1'b0, int'(valid_o), 0);

    // R11: asynchronous reset after a non-zero result
    valid_i   = 1'b1;
    pattern_i = 5'd31;
    @(negedge clk_i);
    valid_i = 1'b0;
    check("R7 pre-reset", count_o == 9'd256, int'(count_o), 256);
    #1 rst_ni = 1'b0;
    #1;
    check("R11 async count", count_o == '0, int'(count_o), 0);
    check("R11 async valid", valid_o == 1'b0, int'(valid_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R11 after release", count_o == '0, int'(count_o), 0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule